// File: doc/BRIEF.md
# Byte Shift, Rotate and Bit-Manipulation Unit

This unit is the execution stage for the second byte of the extended shift/bit opcode space of an 8-bit processor core. It also handles the four short accumulator rotates. Each cycle the core presents an opcode, the operand byte it has already fetched, and the current flag vector. One clock later the unit returns the result byte, a write-back enable, the new flag vector, the operand index the opcode names, whether that operand is the memory byte addressed by the HL pair, and the instruction's cycle cost. The unit fetches nothing itself: the core reads `src_sel_o`/`mem_op_o` to route the write-back and uses `cycles_o` for timing.

The opcode is split into three fields. Bits 7:6 select the group: shift/rotate, bit test, bit clear or bit set. Bits 5:3 select either the shift kind or the bit number. Bits 2:0 select the operand. When `acc_rot_i` is high, the opcode is read as one of the four accumulator rotates. These share their arithmetic with the extended rotates but differ in the zero flag and in cost.

Top module: `shbit_unit`

## Requirements
- R1: While `rst_n` is low, every output is zero.
- R2: All outputs are registered with one cycle of latency. `src_sel_o` equals opcode bits 2:0 (0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 6 memory at HL, 7 A). `mem_op_o` is high only for index 6. In accumulator mode the index is 7 and `mem_op_o` is low.
- R3: In extended mode `cycles_o` is 16 for index 6 and 8 for every other index. In accumulator mode it is 4.
- R4: Flag vectors are {Z,N,H,C} in bits 3..0. Shift kind is opcode bits 5:3. Kind 0 rotates left, putting old bit 7 into both bit 0 and C. Kind 1 rotates right, putting old bit 0 into both bit 7 and C.
- R5: Kind 2 shifts left, with the incoming C entering bit 0 and old bit 7 becoming C. Kind 3 shifts right, with the incoming C entering bit 7 and old bit 0 becoming C.
- R6: Kind 4 shifts left with a zero into bit 0 and old bit 7 into C. Kind 5 shifts right keeping bit 7, with old bit 0 into C. Kind 7 shifts right with a zero into bit 7, with old bit 0 into C.
- R7: Kind 6 exchanges the two nibbles and clears C.
- R8: For extended-mode opcodes 0x00-0x3F, N and H are cleared, Z is set exactly when the result is zero, and `wr_en_o` is high.
- R9: Opcodes 0x40-0x7F test bit n, where n is opcode bits 5:3. Z becomes the inverse of that bit, N is cleared, H is set, C is kept from the input, `wr_en_o` is low, and the result equals the operand.
- R10: Opcodes 0x80-0xBF clear bit n of the operand. `wr_en_o` is high and the flags pass through unchanged.
- R11: Opcodes 0xC0-0xFF set bit n of the operand. `wr_en_o` is high and the flags pass through unchanged.
- R12: With `acc_rot_i` high, opcode bits 4:3 pick kind 0..3 (0x07, 0x0F, 0x17, 0x1F). Z, N and H are cleared whatever the result, C follows the rotate, and `wr_en_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 8 | Opcode byte |
| acc_rot_i | input | 1 | Interpret opcode as an accumulator rotate |
| operand_i | input | 8 | Operand value fetched by the core |
| flags_i | input | 4 | Current flags {Z,N,H,C} |
| result_o | output | 8 | Result byte |
| wr_en_o | output | 1 | Write result back to the operand |
| flags_o | output | 4 | New flags {Z,N,H,C} |
| src_sel_o | output | 3 | Operand index named by the opcode |
| mem_op_o | output | 1 | Operand is the memory byte at HL |
| cycles_o | output | 5 | Instruction cycle cost |

## Verification
The assertions assume that whenever `acc_rot_i` is high, the core presents one of the four accumulator rotate opcodes. They also assume the inputs stay stable from one rising edge through the next. The bench draws random opcodes, operands and flag vectors, and drives them half a period before each edge. When it selects accumulator mode, it builds the opcode from a random 2-bit kind with bits 7:5 zero and bits 2:0 all ones. Directed cases add the edges of carry propagation, sign fill, zero results and bit 7 tests.

// File: rtl/shbit_pkg.sv
package shbit_pkg;

    localparam int DATA_W  = 8;
    localparam int IDX_W   = 3;
    localparam int FLAG_W  = 4;
    localparam int CYC_REG = 8;
    localparam int CYC_MEM = 16;
    localparam int CYC_ACC = 4;
    localparam int CYC_W   = $clog2(CYC_MEM + 1);
    localparam logic [IDX_W-1:0] IDX_MEM = 3'd6;
    localparam logic [IDX_W-1:0] IDX_ACC = 3'd7;

    // flag vector bit positions
    localparam int FZ = 3;
    localparam int FN = 2;
    localparam int FH = 1;
    localparam int FC = 0;

    typedef enum logic [1:0] {
        GRP_SHIFT = 2'b00,
        GRP_TEST  = 2'b01,
        GRP_CLR   = 2'b10,
        GRP_SET   = 2'b11
    } grp_e;

    typedef enum logic [2:0] {
        SH_ROL  = 3'd0,
        SH_ROR  = 3'd1,
        SH_ROLC = 3'd2,
        SH_RORC = 3'd3,
        SH_ASL  = 3'd4,
        SH_ASR  = 3'd5,
        SH_NIB  = 3'd6,
        SH_LSR  = 3'd7
    } shk_e;

    typedef struct packed {
        grp_e             grp;
        logic [2:0]       sel;   // shift kind or bit number
        logic [IDX_W-1:0] src;
        logic             acc;
    } dec_t;

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              wr;
        logic [FLAG_W-1:0] flags;
        logic [IDX_W-1:0]  src;
        logic              mem;
        logic [CYC_W-1:0]  cycles;
    } out_t;

endpackage

// File: rtl/shbit_decode.sv
module shbit_decode
    import shbit_pkg::*;
(
    input  logic [7:0] op_i,
    input  logic       acc_i,
    output dec_t       dec_o
);
    always_comb begin
        dec_o = '0;
        dec_o.acc = acc_i;
        if (acc_i) begin
            dec_o.grp = GRP_SHIFT;
            dec_o.sel = {1'b0, op_i[4:3]};
            dec_o.src = IDX_ACC;
        end else begin
            dec_o.grp = grp_e'(op_i[7:6]);
            dec_o.sel = op_i[5:3];
            dec_o.src = op_i[2:0];
        end
    end
endmodule

// File: rtl/shbit_shifter.sv
module shbit_shifter
    import shbit_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  shk_e         kind_i,
    input  logic [W-1:0] val_i,
    input  logic         cin_i,
    output logic [W-1:0] res_o,
    output logic         cout_o
);
    localparam int HALF = W / 2;

    always_comb begin
        res_o  = val_i;
        cout_o = 1'b0;
        unique case (kind_i)
            SH_ROL:  begin res_o = {val_i[W-2:0], val_i[W-1]}; cout_o = val_i[W-1]; end
            SH_ROR:  begin res_o = {val_i[0], val_i[W-1:1]};   cout_o = val_i[0];   end
            SH_ROLC: begin res_o = {val_i[W-2:0], cin_i};      cout_o = val_i[W-1]; end
            SH_RORC: begin res_o = {cin_i, val_i[W-1:1]};      cout_o = val_i[0];   end
            SH_ASL:  begin res_o = {val_i[W-2:0], 1'b0};       cout_o = val_i[W-1]; end
            SH_ASR:  begin res_o = {val_i[W-1], val_i[W-1:1]}; cout_o = val_i[0];   end
            SH_NIB:  begin res_o = {val_i[HALF-1:0], val_i[W-1:HALF]}; cout_o = 1'b0; end
            SH_LSR:  begin res_o = {1'b0, val_i[W-1:1]};       cout_o = val_i[0];   end
            default: begin res_o = val_i; cout_o = 1'b0; end
        endcase
    end
endmodule

// File: rtl/shbit_bitop.sv
module shbit_bitop
    import shbit_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [2:0]   bitn_i,
    input  logic         set_i,
    input  logic [W-1:0] val_i,
    output logic [W-1:0] res_o,
    output logic         bit_o
);
    logic [W-1:0] mask;

    for (genvar g = 0; g < W; g++) begin : g_mask
        assign mask[g] = (bitn_i == g[2:0]);
    end

    assign bit_o = |(val_i & mask);
    assign res_o = set_i ? (val_i | mask) : (val_i & ~mask);
endmodule

// File: rtl/shbit_unit.sv
module shbit_unit
    import shbit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        op_i,
    input  logic              acc_rot_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [DATA_W-1:0] result_o,
    output logic              wr_en_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic [IDX_W-1:0]  src_sel_o,
    output logic              mem_op_o,
    output logic [CYC_W-1:0]  cycles_o
);
    dec_t              dec;
    logic [DATA_W-1:0] sh_res;
    logic              sh_cout;
    logic [DATA_W-1:0] bo_res;
    logic              bo_bit;
    out_t              st_d, st_q;

    shbit_decode u_dec (
        .op_i  (op_i),
        .acc_i (acc_rot_i),
        .dec_o (dec)
    );

    shbit_shifter #(.W(DATA_W)) u_sh (
        .kind_i (shk_e'(dec.sel)),
        .val_i  (operand_i),
        .cin_i  (flags_i[FC]),
        .res_o  (sh_res),
        .cout_o (sh_cout)
    );

    shbit_bitop #(.W(DATA_W)) u_bo (
        .bitn_i (dec.sel),
        .set_i  (dec.grp == GRP_SET),
        .val_i  (operand_i),
        .res_o  (bo_res),
        .bit_o  (bo_bit)
    );

    always_comb begin
        st_d        = '0;
        st_d.src    = dec.src;
        st_d.mem    = !dec.acc && (dec.src == IDX_MEM);
        if (dec.acc)
            st_d.cycles = CYC_W'(CYC_ACC);
        else if (dec.src == IDX_MEM)
            st_d.cycles = CYC_W'(CYC_MEM);
        else
            st_d.cycles = CYC_W'(CYC_REG);

        unique case (dec.grp)
            GRP_SHIFT: begin
                st_d.result    = sh_res;
                st_d.wr        = 1'b1;
                st_d.flags[FZ] = dec.acc ? 1'b0 : (sh_res == '0);
                st_d.flags[FN] = 1'b0;
                st_d.flags[FH] = 1'b0;
                st_d.flags[FC] = sh_cout;
            end
            GRP_TEST: begin
                st_d.result    = operand_i;
                st_d.wr        = 1'b0;
                st_d.flags[FZ] = ~bo_bit;
                st_d.flags[FN] = 1'b0;
                st_d.flags[FH] = 1'b1;
                st_d.flags[FC] = flags_i[FC];
            end
            default: begin
                st_d.result = bo_res;
                st_d.wr     = 1'b1;
                st_d.flags  = flags_i;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result_o  = st_q.result;
    assign wr_en_o   = st_q.wr;
    assign flags_o   = st_q.flags;
    assign src_sel_o = st_q.src;
    assign mem_op_o  = st_q.mem;
    assign cycles_o  = st_q.cycles;

    // bit test never writes back
    assert_test_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_rot_i && op_i[7:6] == 2'b01) |=> (!wr_en_o && flags_o[FH] && !flags_o[FN]));

    // clear/set keep flags
    assert_bitmod_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_rot_i && op_i[7] == 1'b1) |=> (flags_o == $past(flags_i) && wr_en_o));

    // shift group clears N and H
    assert_shift_nh_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i[7:6] == 2'b00 || acc_rot_i) |=> (!flags_o[FN] && !flags_o[FH]));

    // accumulator rotates clear Z and cost 4
    assert_acc_z_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rot_i |=> (!flags_o[FZ] && cycles_o == CYC_W'(CYC_ACC) && src_sel_o == IDX_ACC));

    // memory operand costs 16
    assert_mem_cycles_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_rot_i && op_i[2:0] == IDX_MEM) |=> (mem_op_o && cycles_o == CYC_W'(CYC_MEM)));

    // nibble exchange clears carry
    assert_swap_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_rot_i && op_i[7:3] == 5'b00110) |=> !flags_o[FC]);

    // reset state
    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (result_o == '0 && !wr_en_o && flags_o == '0 && cycles_o == '0));

endmodule

// File: tb/shbit_unit_tb.sv
`timescale 1ns/1ps
module shbit_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] op = '0;
    logic       acc = 1'b0;
    logic [7:0] val = '0;
    logic [3:0] fl = '0;
    logic [7:0] result;
    logic       wr;
    logic [3:0] flo;
    logic [2:0] sel;
    logic       mem;
    logic [4:0] cyc;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    shbit_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .acc_rot_i(acc),
        .operand_i(val), .flags_i(fl), .result_o(result), .wr_en_o(wr),
        .flags_o(flo), .src_sel_o(sel), .mem_op_o(mem), .cycles_o(cyc)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (op 0x%02h acc %0b val 0x%02h fl 0x%0h)",
                     req, act, exp, op, acc, val, fl);
        end
    endtask

    // reference model: {result, wr, Z, N, H, C}
    function automatic logic [12:0] model(input logic [7:0] o, input logic a,
                                          input logic [7:0] v, input logic [3:0] f);
        int k, g;
        logic [8:0] wide;
        logic [7:0] r;
        logic c, cin, w, z, n, h;
        cin = f[0];
        k = a ? int'(o[4:3]) : int'(o[5:3]);
        g = a ? 0 : int'(o[7:6]);
        r = v; c = cin; w = 1'b1; z = f[3]; n = f[2]; h = f[1];
        if (g == 0) begin
            case (k)
                0: begin wide = {1'b0, v} << 1; r = wide[7:0] | {7'b0, wide[8]}; c = wide[8]; end
                1: begin r = (v >> 1) | (v << 7); c = v[0]; end
                2: begin wide = {1'b0, v} << 1; r = wide[7:0] | {7'b0, cin}; c = wide[8]; end
                3: begin r = (v >> 1) | ({7'b0, cin} << 7); c = v[0]; end
                4: begin r = v << 1; c = v[7]; end
                5: begin r = (v >> 1) | (v & 8'h80); c = v[0]; end
                6: begin r = (v << 4) | (v >> 4); c = 1'b0; end
                default: begin r = v >> 1; c = v[0]; end
            endcase
            z = a ? 1'b0 : (r == 8'h00);
            n = 1'b0; h = 1'b0;
        end else if (g == 1) begin
            w = 1'b0; z = ((v >> k) & 8'h01) == 8'h00; n = 1'b0; h = 1'b1;
        end else if (g == 2) begin
            r = v & ~(8'h01 << k);
        end else begin
            r = v | (8'h01 << k);
        end
        return {r, w, z, n, h, c};
    endfunction

    function automatic string tag(input logic [7:0] o, input logic a);
        if (a) return "R12";
        case (o[7:6])
            2'b01: return "R9";
            2'b10: return "R10";
            2'b11: return "R11";
            default: case (o[5:3])
                3'd0, 3'd1: return "R4";
                3'd2, 3'd3: return "R5";
                3'd6:       return "R7";
                default:    return "R6";
            endcase
        endcase
    endfunction

    task automatic apply(input logic [7:0] o, input logic a, input logic [7:0] v, input logic [3:0] f);
        logic [12:0] e;
        @(negedge clk);
        op = o; acc = a; val = v; fl = f;
        e = model(o, a, v, f);
        @(negedge clk);
        check(tag(o, a), {23'b0, result, wr}, {23'b0, e[12:4]});
        check((!a && o[7:6] == 2'b00) ? "R8" : tag(o, a), {28'b0, flo}, {28'b0, e[3:0]});
        check("R2", {28'b0, sel, mem}, a ? 32'he : {28'b0, o[2:0], o[2:0] == 3'd6});
        check("R3", {27'b0, cyc}, a ? 32'd4 : (o[2:0] == 3'd6 ? 32'd16 : 32'd8));
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {18'b0, result, wr, flo}, 32'b0);
        check("R1", {23'b0, sel, mem, cyc}, 32'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // directed corners
        apply(8'h00, 1'b0, 8'h80, 4'h0);   // R4 rotate left, bit7 wraps
        apply(8'h09, 1'b0, 8'h01, 4'h0);   // R4 rotate right
        apply(8'h12, 1'b0, 8'h80, 4'h1);   // R5 carry in, result 0x01
        apply(8'h12, 1'b0, 8'h80, 4'h0);   // R5 zero result
        apply(8'h1B, 1'b0, 8'h00, 4'h1);   // R5 carry into bit7
        apply(8'h2C, 1'b0, 8'h80, 4'h0);   // R6 sign fill
        apply(8'h3D, 1'b0, 8'h01, 4'h0);   // R6 logical to zero
        apply(8'h24, 1'b0, 8'hFF, 4'h0);   // R6 arithmetic left
        apply(8'h36, 1'b0, 8'hF0, 4'hF);   // R7 swap from memory
        apply(8'h7E, 1'b0, 8'h7F, 4'h1);   // R9 bit7 clear -> Z
        apply(8'h47, 1'b0, 8'h01, 4'h0);   // R9 bit0 set
        apply(8'hBE, 1'b0, 8'hFF, 4'hA);   // R10
        apply(8'hC0, 1'b0, 8'h00, 4'h5);   // R11
        apply(8'h07, 1'b1, 8'h80, 4'h0);   // R12 result 0x01
        apply(8'h17, 1'b1, 8'h80, 4'h0);   // R12 zero result, Z still 0
        apply(8'h1F, 1'b1, 8'h01, 4'h1);   // R12
        apply(8'h0F, 1'b1, 8'h00, 4'hF);   // R12

        for (int i = 0; i < 400; i++) begin
            logic a;
            logic [7:0] o;
            a = ($urandom % 5) == 0;
            o = a ? {3'b000, 2'($urandom), 3'b111} : 8'($urandom);
            apply(o, a, 8'($urandom), 4'($urandom));
        end

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule